// File: doc/BRIEF.md
# Page Fault Replacement Sequencer

This block services one page fault at a time for a small physical memory split into a power-of-two number of frames. The memory management logic hands it the virtual page number that missed. The block then picks the frame to reuse. An unoccupied frame is taken when one exists. Otherwise a clock-hand scan over per-frame use bits picks the frame, which approximates least-recently-used replacement. The block asks an external mover to copy the victim to disk, but only when the victim is dirty. It then writes the victim's page descriptor as not present, asks the mover to read the faulting page into the freed frame, and writes the faulting page's descriptor as present in that frame. Last, it pulses a restart so that the faulting access is executed again from its start.

The block keeps its own copies of the frame-to-page mapping and of each frame's use and dirty bits. While it is idle, hit reports from the translation path set these bits. A page's disk slot is its virtual page number. Each descriptor write clears the use and dirty bits of the page it addresses.

Top module: `page_fault_seq`

## Requirements
- R1: After reset, `fault_ready` is 1 and `xfer_req`, `pt_we` and `restart` are 0. All frames are unoccupied, all use and dirty bits are clear, and the clock hand points at frame 0.
- R2: When a fault is accepted and some frame is unoccupied, the lowest-numbered unoccupied frame is used. No disk write and no invalidating descriptor write happen, and the clock hand does not move.
- R3: When every frame is occupied, the scan starts at the clock hand. A frame whose use bit is set has that bit cleared and is passed over. The first frame found with a clear use bit becomes the victim, and the hand then points one frame past the victim, wrapping at the last frame.
- R4: A victim whose dirty bit is set first gets a transfer request with `xfer_to_disk`=1, `xfer_pfn` equal to the victim frame and `xfer_slot` equal to the page number it holds. A clean victim gets no such request.
- R5: In the cycle after the write-back completes, or right after selection for a clean victim, one descriptor write is made for the victim's page with `pt_present`=0, `pt_slot` equal to that page number and `pt_pfn`=0.
- R6: In the cycle after the invalidating write, or right after selection of a free frame, a transfer request is made with `xfer_to_disk`=0, `xfer_pfn` equal to the chosen frame and `xfer_slot` equal to the faulting page number.
- R7: In the cycle after the read completes, one descriptor write is made for the faulting page with `pt_present`=1, `pt_pfn` equal to the chosen frame and `pt_slot`=0. The frame's copy now holds that page with its use and dirty bits clear.
- R8: `restart` is a one-cycle pulse one cycle after the installing descriptor write. It carries the faulting page in `restart_vpn` and its frame in `restart_pfn`. `fault_ready` returns to 1 in the following cycle.
- R9: `fault_ready` is 0 from the cycle after a fault is accepted until the cycle after `restart`. A fault offered while `fault_ready` is 0 is ignored.
- R10: While idle, a hit report (`access_valid`=1) sets the use bit of frame `access_pfn`, and also its dirty bit when `access_write`=1.
- R11: A transfer request, together with its direction, frame and slot, stays asserted and unchanged until the cycle in which `xfer_done` is sampled as 1.
- R12: With frames 0 to 3 holding pages 2, 1, 5 and 6, the hand at frame 0, and only pages 1, 5 and 6 used since they were loaded, a fault on page 0 evicts page 2 from frame 0 without a write-back and loads page 0 into frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_valid | input | 1 | A faulting page is offered |
| fault_vpn | input | VPN_W | Faulting virtual page number |
| fault_ready | output | 1 | Block is idle and accepts a fault |
| access_valid | input | 1 | Hit report from the translation path |
| access_pfn | input | PFN_W | Frame that was hit |
| access_write | input | 1 | The hit was a write |
| xfer_req | output | 1 | Transfer request to the mover, held until done |
| xfer_to_disk | output | 1 | 1: memory to disk, 0: disk to memory |
| xfer_pfn | output | PFN_W | Frame involved in the transfer |
| xfer_slot | output | VPN_W | Disk slot (page number) involved |
| xfer_done | input | 1 | One-cycle completion pulse from the mover |
| pt_we | output | 1 | Page descriptor write strobe |
| pt_vpn | output | VPN_W | Page whose descriptor is written |
| pt_present | output | 1 | Presence value written |
| pt_pfn | output | PFN_W | Frame number written |
| pt_slot | output | VPN_W | Disk slot written |
| restart | output | 1 | Faulting access may be restarted |
| restart_vpn | output | VPN_W | Page that was brought in |
| restart_pfn | output | PFN_W | Frame that now holds it |

## Verification
Every output is a register loaded from the next state. So `fault_ready` falls one cycle after acceptance, and each descriptor write or transfer request appears in the cycle right after the step before it completes. The one exception is the first step after acceptance, which waits one cycle plus one cycle per skipped frame. The bench samples at falling edges. It requires each later step to appear at the very next sample, and it times `restart` and the return of `fault_ready` the same way. An arithmetic model of the clock hand, the free-frame search and the dirty bits predicts the victim, the order of steps and every field for a directed case and for a long random run of hits and faults on the four-frame default.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_WRITEBACK,
    ST_INVALIDATE,
    ST_FETCH,
    ST_INSTALL,
    ST_DONE
  } pfs_state_e;
endpackage

// File: rtl/pfs_frame_table.sv
// Per-frame shadow state: occupancy, resident page, use and dirty bits.
module pfs_frame_table #(
  parameter int VPN_W = 4,
  parameter int PFN_W = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       touch_en,
  input  logic [PFN_W-1:0]           touch_idx,
  input  logic                       touch_wr,
  input  logic                       clear_en,
  input  logic [PFN_W-1:0]           clear_idx,
  input  logic                       install_en,
  input  logic [PFN_W-1:0]           install_idx,
  input  logic [VPN_W-1:0]           install_vpn,
  input  logic [PFN_W-1:0]           rd_idx,
  output logic [VPN_W-1:0]           rd_vpn,
  output logic [(1<<PFN_W)-1:0]      use_vec,
  output logic [(1<<PFN_W)-1:0]      dirty_vec,
  output logic                       free_found,
  output logic [PFN_W-1:0]           free_idx
);
  localparam int FRAMES = 1 << PFN_W;

  logic [FRAMES-1:0] occ_q;
  logic [FRAMES-1:0] use_q;
  logic [FRAMES-1:0] dirty_q;
  logic [VPN_W-1:0]  vpn_mem [FRAMES];

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q   <= '0;
      use_q   <= '0;
      dirty_q <= '0;
    end else begin
      if (touch_en) begin
        use_q[touch_idx] <= 1'b1;
        if (touch_wr) dirty_q[touch_idx] <= 1'b1;
      end
      if (clear_en) use_q[clear_idx] <= 1'b0;
      if (install_en) begin
        occ_q[install_idx]   <= 1'b1;
        use_q[install_idx]   <= 1'b0;
        dirty_q[install_idx] <= 1'b0;
      end
    end
  end

  // Page-number store kept reset-free so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (install_en) vpn_mem[install_idx] <= install_vpn;
  end

  assign rd_vpn    = vpn_mem[rd_idx];
  assign use_vec   = use_q;
  assign dirty_vec = dirty_q;

  // Lowest-numbered unoccupied frame wins.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = FRAMES - 1; i >= 0; i--) begin
      if (!occ_q[i]) begin
        free_found = 1'b1;
        free_idx   = PFN_W'(i);
      end
    end
  end
endmodule

// File: rtl/pfs_clock_hand.sv
// Replacement pointer that sweeps the frames in a ring.
module pfs_clock_hand #(
  parameter int PFN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [PFN_W-1:0] hand
);
  localparam int FRAMES = 1 << PFN_W;
  localparam logic [PFN_W-1:0] LAST = PFN_W'(FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hand <= '0;
    end else if (advance) begin
      hand <= (hand == LAST) ? '0 : hand + 1'b1;
    end
  end
endmodule

// File: rtl/page_fault_seq.sv
module page_fault_seq #(
  parameter int VPN_W = 4,
  parameter int PFN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_valid,
  input  logic [VPN_W-1:0] fault_vpn,
  output logic             fault_ready,
  input  logic             access_valid,
  input  logic [PFN_W-1:0] access_pfn,
  input  logic             access_write,
  output logic             xfer_req,
  output logic             xfer_to_disk,
  output logic [PFN_W-1:0] xfer_pfn,
  output logic [VPN_W-1:0] xfer_slot,
  input  logic             xfer_done,
  output logic             pt_we,
  output logic [VPN_W-1:0] pt_vpn,
  output logic             pt_present,
  output logic [PFN_W-1:0] pt_pfn,
  output logic [VPN_W-1:0] pt_slot,
  output logic             restart,
  output logic [VPN_W-1:0] restart_vpn,
  output logic [PFN_W-1:0] restart_pfn
);
  import pfs_pkg::*;

  localparam int FRAMES = 1 << PFN_W;

  pfs_state_e       state_q, state_n;
  logic [VPN_W-1:0] fvpn_q, fvpn_n;
  logic [PFN_W-1:0] vic_q, vic_n;
  logic [VPN_W-1:0] vvpn_q, vvpn_n;

  logic             hand_adv;
  logic             use_clr;
  logic [PFN_W-1:0] hand;
  logic [VPN_W-1:0] hand_vpn;
  logic [FRAMES-1:0] use_vec;
  logic [FRAMES-1:0] dirty_vec;
  logic             free_found;
  logic [PFN_W-1:0] free_idx;

  pfs_frame_table #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_frames (
    .clk         (clk),
    .rst         (rst),
    .touch_en    (state_q == ST_IDLE && access_valid),
    .touch_idx   (access_pfn),
    .touch_wr    (access_write),
    .clear_en    (use_clr),
    .clear_idx   (hand),
    .install_en  (state_q == ST_INSTALL),
    .install_idx (vic_q),
    .install_vpn (fvpn_q),
    .rd_idx      (hand),
    .rd_vpn      (hand_vpn),
    .use_vec     (use_vec),
    .dirty_vec   (dirty_vec),
    .free_found  (free_found),
    .free_idx    (free_idx)
  );

  pfs_clock_hand #(.PFN_W(PFN_W)) u_hand (
    .clk     (clk),
    .rst     (rst),
    .advance (hand_adv),
    .hand    (hand)
  );

  always_comb begin
    state_n  = state_q;
    fvpn_n   = fvpn_q;
    vic_n    = vic_q;
    vvpn_n   = vvpn_q;
    hand_adv = 1'b0;
    use_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fault_valid) begin
          fvpn_n  = fault_vpn;
          state_n = ST_SELECT;
        end
      end
      ST_SELECT: begin
        if (free_found) begin
          vic_n   = free_idx;
          state_n = ST_FETCH;
        end else if (use_vec[hand]) begin
          use_clr  = 1'b1;
          hand_adv = 1'b1;
        end else begin
          vic_n    = hand;
          vvpn_n   = hand_vpn;
          hand_adv = 1'b1;
          state_n  = dirty_vec[hand] ? ST_WRITEBACK : ST_INVALIDATE;
        end
      end
      ST_WRITEBACK:  if (xfer_done) state_n = ST_INVALIDATE;
      ST_INVALIDATE: state_n = ST_FETCH;
      ST_FETCH:      if (xfer_done) state_n = ST_INSTALL;
      ST_INSTALL:    state_n = ST_DONE;
      ST_DONE:       state_n = ST_IDLE;
      default:       state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      fvpn_q       <= '0;
      vic_q        <= '0;
      vvpn_q       <= '0;
      fault_ready  <= 1'b1;
      xfer_req     <= 1'b0;
      xfer_to_disk <= 1'b0;
      xfer_pfn     <= '0;
      xfer_slot    <= '0;
      pt_we        <= 1'b0;
      pt_vpn       <= '0;
      pt_present   <= 1'b0;
      pt_pfn       <= '0;
      pt_slot      <= '0;
      restart      <= 1'b0;
      restart_vpn  <= '0;
      restart_pfn  <= '0;
    end else begin
      state_q      <= state_n;
      fvpn_q       <= fvpn_n;
      vic_q        <= vic_n;
      vvpn_q       <= vvpn_n;
      fault_ready  <= (state_n == ST_IDLE);
      xfer_req     <= (state_n == ST_WRITEBACK) || (state_n == ST_FETCH);
      xfer_to_disk <= (state_n == ST_WRITEBACK);
      xfer_pfn     <= vic_n;
      xfer_slot    <= (state_n == ST_WRITEBACK) ? vvpn_n : fvpn_n;
      pt_we        <= (state_n == ST_INVALIDATE) || (state_n == ST_INSTALL);
      pt_vpn       <= (state_n == ST_INVALIDATE) ? vvpn_n : fvpn_n;
      pt_present   <= (state_n == ST_INSTALL);
      pt_pfn       <= (state_n == ST_INSTALL) ? vic_n : '0;
      pt_slot      <= (state_n == ST_INVALIDATE) ? vvpn_n : '0;
      restart      <= (state_n == ST_DONE);
      restart_vpn  <= fvpn_n;
      restart_pfn  <= vic_n;
    end
  end
endmodule

// File: rtl/page_fault_seq_checks.sv
module page_fault_seq_checks #(
  parameter int VPN_W = 4,
  parameter int PFN_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             fault_valid,
  input logic             fault_ready,
  input logic             xfer_req,
  input logic             xfer_to_disk,
  input logic [PFN_W-1:0] xfer_pfn,
  input logic [VPN_W-1:0] xfer_slot,
  input logic             xfer_done,
  input logic             pt_we,
  input logic [VPN_W-1:0] pt_vpn,
  input logic             pt_present,
  input logic [PFN_W-1:0] pt_pfn,
  input logic [VPN_W-1:0] pt_slot,
  input logic             restart,
  input logic [VPN_W-1:0] restart_vpn,
  input logic [PFN_W-1:0] restart_pfn
);
  assert_one_action_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xfer_req, pt_we, restart}));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_req || pt_we || restart) |-> !fault_ready);

  assert_accept_drops_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_ready) |=> !fault_ready);

  assert_request_held_R11: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_to_disk)
                                   && $stable(xfer_pfn) && $stable(xfer_slot)));

  assert_writeback_then_invalidate_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && xfer_to_disk && xfer_done) |=>
      (pt_we && !pt_present && pt_vpn == $past(xfer_slot)));

  assert_invalidate_fields_R5: assert property (@(posedge clk) disable iff (rst)
    (pt_we && !pt_present) |-> (pt_slot == pt_vpn && pt_pfn == '0));

  assert_fetch_after_invalidate_R6: assert property (@(posedge clk) disable iff (rst)
    (pt_we && !pt_present) |=> (xfer_req && !xfer_to_disk));

  assert_restart_after_install_R8: assert property (@(posedge clk) disable iff (rst)
    restart |-> ($past(pt_we) && $past(pt_present)
                 && $past(pt_pfn) == restart_pfn && $past(pt_vpn) == restart_vpn));

  assert_ready_after_restart_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (fault_ready && !restart));
endmodule

bind page_fault_seq page_fault_seq_checks #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_checks (.*);

// File: tb/page_fault_seq_bench.sv
module page_fault_seq_bench;
  localparam int VPN_W  = 4;
  localparam int PFN_W  = 2;
  localparam int FRAMES = 1 << PFN_W;
  localparam int PAGES  = 1 << VPN_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fault_valid = 1'b0;
  logic [VPN_W-1:0] fault_vpn = '0;
  logic             fault_ready;
  logic             access_valid = 1'b0;
  logic [PFN_W-1:0] access_pfn = '0;
  logic             access_write = 1'b0;
  logic             xfer_req;
  logic             xfer_to_disk;
  logic [PFN_W-1:0] xfer_pfn;
  logic [VPN_W-1:0] xfer_slot;
  logic             xfer_done = 1'b0;
  logic             pt_we;
  logic [VPN_W-1:0] pt_vpn;
  logic             pt_present;
  logic [PFN_W-1:0] pt_pfn;
  logic [VPN_W-1:0] pt_slot;
  logic             restart;
  logic [VPN_W-1:0] restart_vpn;
  logic [PFN_W-1:0] restart_pfn;

  page_fault_seq #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_page_fault_seq (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Reference model state
  bit               m_occ   [FRAMES];
  bit               m_use   [FRAMES];
  bit               m_dirty [FRAMES];
  logic [VPN_W-1:0] m_vpn   [FRAMES];
  bit               m_res   [PAGES];
  int               m_hand = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic touch(input int f, input bit wr);
    @(negedge clk);
    access_valid = 1'b1;
    access_pfn   = PFN_W'(f);
    access_write = wr;
    @(negedge clk);
    access_valid = 1'b0;
    access_write = 1'b0;
    m_use[f] = 1'b1;
    if (wr) m_dirty[f] = 1'b1;
  endtask

  // Step codes: 0 write-back, 1 invalidate, 2 fetch, 3 install, 4 restart
  task automatic do_fault(input logic [VPN_W-1:0] v, input bit poke, input string tag);
    int vic;
    bit evict;
    bit wb;
    logic [VPN_W-1:0] vv;
    int steps [5];
    int n;
    int gap;
    int lat;
    logic [7:0]  xa, xe;
    logic [11:0] pa, pe;
    logic [6:0]  ra, re;

    vic = -1;
    vv  = '0;
    wb  = 1'b0;
    for (int i = FRAMES - 1; i >= 0; i--) if (!m_occ[i]) vic = i;
    evict = (vic < 0);
    if (evict) begin
      while (m_use[m_hand]) begin
        m_use[m_hand] = 1'b0;
        m_hand = (m_hand + 1) % FRAMES;
      end
      vic    = m_hand;
      m_hand = (m_hand + 1) % FRAMES;
      wb     = m_dirty[vic];
      vv     = m_vpn[vic];
    end
    n = 0;
    if (evict && wb) begin steps[n] = 0; n++; end
    if (evict)       begin steps[n] = 1; n++; end
    steps[n] = 2; n++;
    steps[n] = 3; n++;
    steps[n] = 4; n++;

    @(negedge clk);
    fault_valid = 1'b1;
    fault_vpn   = v;
    @(negedge clk);
    if (poke) fault_vpn = v ^ 4'h7;
    else      fault_valid = 1'b0;
    chk(fault_ready == 1'b0, {tag, " R9 ready after accept"}, int'(fault_ready), 0);

    for (int i = 0; i < n; i++) begin
      gap = 0;
      while (!(xfer_req || pt_we || restart) && gap < 64) begin
        @(negedge clk);
        gap++;
      end
      if (i > 0) chk(gap == 0, {tag, " R5 R6 R7 R8 step spacing"}, gap, 0);
      case (steps[i])
        0, 2: begin
          xa = {xfer_req, xfer_to_disk, xfer_pfn, xfer_slot};
          xe = (steps[i] == 0) ? {1'b1, 1'b1, PFN_W'(vic), vv}
                               : {1'b1, 1'b0, PFN_W'(vic), v};
          chk(xa == xe, (steps[i] == 0) ? {tag, " R3 R4 write-back"}
                                        : {tag, " R2 R3 R6 fetch"}, int'(xa), int'(xe));
          lat = $urandom_range(0, 3);
          repeat (lat) @(negedge clk);
          xa = {xfer_req, xfer_to_disk, xfer_pfn, xfer_slot};
          chk(xa == xe, {tag, " R11 request held"}, int'(xa), int'(xe));
          xfer_done = 1'b1;
          @(negedge clk);
          xfer_done = 1'b0;
          if (poke) begin
            fault_valid = 1'b0;
            poke = 1'b0;
          end
        end
        1, 3: begin
          pa = {pt_we, pt_present, pt_pfn, pt_slot, pt_vpn};
          pe = (steps[i] == 1) ? {1'b1, 1'b0, PFN_W'(0), vv, vv}
                               : {1'b1, 1'b1, PFN_W'(vic), VPN_W'(0), v};
          chk(pa == pe, (steps[i] == 1) ? {tag, " R5 invalidate"}
                                        : {tag, " R7 install"}, int'(pa), int'(pe));
          @(negedge clk);
        end
        default: begin
          ra = {restart, restart_vpn, restart_pfn};
          re = {1'b1, v, PFN_W'(vic)};
          chk(ra == re, {tag, " R8 restart"}, int'(ra), int'(re));
          chk(fault_ready == 1'b0, {tag, " R9 ready with restart"}, int'(fault_ready), 0);
          @(negedge clk);
          chk(fault_ready && !restart, {tag, " R8 ready after restart"},
              int'({fault_ready, restart}), 2);
        end
      endcase
    end

    if (evict) m_res[vv] = 1'b0;
    m_occ[vic]   = 1'b1;
    m_vpn[vic]   = v;
    m_use[vic]   = 1'b0;
    m_dirty[vic] = 1'b0;
    m_res[v]     = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VPN_W-1:0] pv;
    for (int i = 0; i < FRAMES; i++) begin
      m_occ[i] = 0; m_use[i] = 0; m_dirty[i] = 0; m_vpn[i] = '0;
    end
    for (int i = 0; i < PAGES; i++) m_res[i] = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(fault_ready == 1'b1, "R1 ready", int'(fault_ready), 1);
    chk(xfer_req == 1'b0, "R1 xfer_req", int'(xfer_req), 0);
    chk(pt_we == 1'b0, "R1 pt_we", int'(pt_we), 0);
    chk(restart == 1'b0, "R1 restart", int'(restart), 0);

    // Fill the frames through the free-frame path
    do_fault(4'd2, 1'b0, "fill");
    do_fault(4'd1, 1'b0, "fill");
    do_fault(4'd5, 1'b0, "fill");
    do_fault(4'd6, 1'b0, "fill");

    // Directed LRU case; hit reports drive the choice (R10)
    touch(1, 1'b1);
    touch(2, 1'b0);
    touch(3, 1'b0);
    do_fault(4'd0, 1'b1, "R12 R10");
    repeat (3) begin
      @(negedge clk);
      chk(fault_ready && !xfer_req && !pt_we && !restart, "R9 busy offer ignored",
          int'({fault_ready, xfer_req, pt_we, restart}), 8);
    end

    // Random hits and faults
    for (int k = 0; k < 150; k++) begin
      for (int t = 0; t < $urandom_range(0, 4); t++)
        touch($urandom_range(0, FRAMES - 1), 1'($urandom_range(0, 1)));
      pv = VPN_W'($urandom_range(0, PAGES - 1));
      while (m_res[pv]) pv = VPN_W'($urandom_range(0, PAGES - 1));
      do_fault(pv, 1'b0, "rand R3 R10");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule